// File: doc/BRIEF.md
# Serial EEPROM Word Read Sequencer

This block fetches one 16-bit word at a time from a three-wire serial EEPROM (chip select, shift clock, serial data toward the memory, serial data from the memory). A one-cycle request carrying a 6-bit word address starts a transfer. The sequencer first holds chip select low for one phase and then raises it. It shifts out an 11-bit read command, most significant bit first, and clocks in 16 data bits. Finally it releases chip select and returns the assembled word with its two bytes exchanged, marked by a one-cycle done strobe.

Every step of the pin pattern lasts one phase. A phase is `div_half + 1` clock cycles. The divider value is captured when a request is accepted, so the pin timing can be slowed to suit a slow memory without changing the sequence. Reading all 32 words of a small ROM is a loop of 32 requests. Firmware then picks fields out of the returned image; the station address, for example, starts at byte offset 20.

Top module: `ee_word_reader`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `ee_cs`, `ee_sk` and `ee_di` are all 0.
- R2: The command holds 11 bits shifted MSB first: two 0 bits, then the read code 1,1,0, then the 6 address bits from bit 5 down to bit 0. This is the value `(6 << 6) | addr`.
- R3: For each command bit, `ee_di` is set while `ee_sk` is low. `ee_sk` then goes high for one phase and then low for one phase, and `ee_di` does not change while `ee_sk` is high.
- R4: After acceptance, `ee_cs` stays low for exactly one phase and then rises before the first shift clock. `ee_sk` is never high while `ee_cs` is low.
- R5: After the command, exactly 16 more shift-clock pulses occur, giving 27 per transfer. `ee_do` is sampled at the end of each high phase and shifted in, first bit as the MSB of the raw word.
- R6: `rd_word` equals the raw 16-bit word with bits [7:0] moved to [15:8] and bits [15:8] moved to [7:0].
- R7: A phase lasts `div_half + 1` cycles. `done` rises exactly 68 × (`div_half` + 1) cycles after the accepting edge. The divider value is latched at acceptance, and changes during a transfer have no effect.
- R8: `busy` is high from the cycle after acceptance until the cycle in which `done` is high. `req_valid` while busy is ignored.
- R9: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R10: `ee_di` is held at 0 during the 16-bit read phase.
- R11: A sweep of word addresses 0 to 31 returns each stored word, byte-swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a read; accepted only when idle |
| req_addr | input | 6 | Word address for the read |
| div_half | input | 8 | Phase length minus one, in clock cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle strobe; `rd_word` is valid |
| rd_word | output | 16 | Byte-swapped word read |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Shift clock to the EEPROM |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach is a change of `div_half` or a second `req_valid` arriving in the middle of a transfer. Both must leave the pin timing and the returned word untouched. The bench injects both at fixed cycle offsets after acceptance. It then checks the exact latency, the returned word, and that no second transfer follows. A behavioural EEPROM in the bench rebuilds the command from the pins, counts shift-clock pulses and watches `ee_di` around each pulse. This exposes sampling and hold errors that the returned word alone would hide.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CS_LO,
    ST_CS_HI,
    ST_C_SET,
    ST_C_RISE,
    ST_C_FALL,
    ST_R_HI,
    ST_R_LO,
    ST_FIN
  } seq_state_t;

  localparam logic [2:0] READ_CODE = 3'b110;
endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ee_cmd_shift.sv
module ee_cmd_shift #(
  parameter int CMD_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [CMD_W-1:0] load_val,
  output logic             msb_nxt
);
  logic [CMD_W-1:0] sr_q;

  always_comb begin
    if (load)       msb_nxt = load_val[CMD_W-1];
    else if (shift) msb_nxt = sr_q[CMD_W-2];
    else            msb_nxt = sr_q[CMD_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst)        sr_q <= '0;
    else if (load)  sr_q <= load_val;
    else if (shift) sr_q <= {sr_q[CMD_W-2:0], 1'b0};
  end
endmodule

// File: rtl/ee_data_capture.sv
module ee_data_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sample,
  input  logic              bit_in,
  output logic [DATA_W-1:0] raw
);
  always_ff @(posedge clk) begin
    if (rst || clr)  raw <= '0;
    else if (sample) raw <= {raw[DATA_W-2:0], bit_in};
  end
endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import ee_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DIV_W-1:0]  div_half,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_word,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int CMD_W  = ADDR_W + 5;
  localparam int MAXB   = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W  = $clog2(MAXB);
  localparam int HALF_W = DATA_W / 2;

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic [DIV_W-1:0] div_q;
  logic             tick, accept, cmd_load, cmd_shift, cmd_msb_nxt, smp;
  logic [CMD_W-1:0] cmd_word;
  logic [DATA_W-1:0] raw;

  assign accept   = (st_q == ST_IDLE) && req_valid;
  assign cmd_word = CMD_W'({READ_CODE, req_addr});

  ee_phase_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst(rst), .clear(accept), .run(st_q != ST_IDLE),
    .limit(div_q), .tick(tick)
  );

  ee_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst(rst), .load(cmd_load), .shift(cmd_shift),
    .load_val(cmd_word), .msb_nxt(cmd_msb_nxt)
  );

  ee_data_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .clr(accept), .sample(smp),
    .bit_in(ee_do), .raw(raw)
  );

  always_comb begin
    st_d      = st_q;
    bit_d     = bit_q;
    cmd_load  = accept;
    cmd_shift = 1'b0;
    smp       = 1'b0;
    case (st_q)
      ST_IDLE:  if (req_valid) st_d = ST_CS_LO;
      ST_CS_LO: if (tick) st_d = ST_CS_HI;
      ST_CS_HI: if (tick) begin
        st_d  = ST_C_SET;
        bit_d = CNT_W'(CMD_W - 1);
      end
      ST_C_SET:  if (tick) st_d = ST_C_RISE;
      ST_C_RISE: if (tick) st_d = ST_C_FALL;
      ST_C_FALL: if (tick) begin
        if (bit_q == '0) begin
          st_d  = ST_R_HI;
          bit_d = CNT_W'(DATA_W - 1);
        end else begin
          st_d      = ST_C_SET;
          bit_d     = bit_q - 1'b1;
          cmd_shift = 1'b1;
        end
      end
      ST_R_HI: if (tick) begin
        st_d = ST_R_LO;
        smp  = 1'b1;
      end
      ST_R_LO: if (tick) begin
        if (bit_q == '0) begin
          st_d = ST_FIN;
        end else begin
          st_d  = ST_R_HI;
          bit_d = bit_q - 1'b1;
        end
      end
      ST_FIN:  if (tick) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      div_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_word <= '0;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_di   <= 1'b0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      if (accept) div_q <= div_half;
      busy  <= (st_d != ST_IDLE);
      done  <= (st_q == ST_FIN) && tick;
      if ((st_q == ST_FIN) && tick)
        rd_word <= {raw[HALF_W-1:0], raw[DATA_W-1:HALF_W]};
      ee_cs <= (st_d != ST_IDLE) && (st_d != ST_CS_LO) && (st_d != ST_FIN);
      ee_sk <= (st_d == ST_C_RISE) || (st_d == ST_R_HI);
      ee_di <= ((st_d == ST_C_SET) || (st_d == ST_C_RISE) || (st_d == ST_C_FALL))
               && cmd_msb_nxt;
    end
  end
endmodule

// File: rtl/ee_word_reader_chk.sv
module ee_word_reader_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> ee_cs) else $error("sk high with cs low"); // R4
  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> busy) else $error("cs rose while idle"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ee_cs && !ee_sk && !ee_di)) else $error("pins active while idle"); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done with busy"); // R9
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done) else $error("busy dropped without done"); // R8
  AST_DI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di)) else $error("di moved with sk high"); // R3
endmodule

bind ee_word_reader ee_word_reader_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/sim_ee_word_reader.sv
module sim_ee_word_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [7:0]  div_half = '0;
  logic        busy, done, ee_cs, ee_sk, ee_di;
  logic [15:0] rd_word;
  logic        ee_do;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ee_word_reader u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .div_half(div_half), .busy(busy), .done(done), .rd_word(rd_word),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] rom_word(input logic [5:0] a);
    logic [15:0] v;
    v = 16'({10'd0, a} * 16'h1F3B);
    return v ^ 16'hC35A;
  endfunction

  function automatic logic [15:0] swp(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  // behavioural EEPROM
  logic        m_sk_q, m_cs_q, m_di_rise;
  logic [10:0] m_cmd, m_last_cmd;
  logic [15:0] m_sr;
  int          m_rise, m_last_rises, hold_err, rdlow_err;

  always @(posedge clk) begin
    if (rst) begin
      m_sk_q <= 0; m_cs_q <= 0; m_di_rise <= 0; m_cmd <= '0; m_last_cmd <= '0;
      m_sr <= '0; m_rise <= 0; m_last_rises <= 0; hold_err <= 0; rdlow_err <= 0;
      ee_do <= 1'b0;
    end else begin
      m_sk_q <= ee_sk;
      m_cs_q <= ee_cs;
      if (!ee_cs) begin
        if (m_cs_q) begin
          m_last_rises <= m_rise;
          m_last_cmd   <= m_cmd;
        end
        m_rise <= 0;
        ee_do  <= 1'b0;
      end else begin
        if (ee_sk && !m_sk_q) begin
          m_rise    <= m_rise + 1;
          m_di_rise <= ee_di;
          if (m_rise < 11) m_cmd <= {m_cmd[9:0], ee_di};
          else if (ee_di) rdlow_err <= rdlow_err + 1;
          if (m_rise == 10) begin
            m_sr  <= rom_word({m_cmd[4:0], ee_di});
            ee_do <= rom_word({m_cmd[4:0], ee_di})[15];
          end
        end
        if (!ee_sk && m_sk_q) begin
          if (m_rise <= 11 && ee_di != m_di_rise) hold_err <= hold_err + 1;
          if (m_rise >= 12) begin
            m_sr  <= {m_sr[14:0], 1'b0};
            ee_do <= m_sr[14];
          end
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // runs one transfer; lat = cycles from accepting edge to done, csd = to cs high
  task automatic do_read(input logic [5:0] a, input logic [7:0] d,
                         input int div_new, input int ign_addr,
                         output logic [15:0] w, output int lat, output int csd,
                         output int busy_err);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; div_half = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; csd = -1; busy_err = 0; lat = -1;
    while (n < 20000) begin
      if (csd < 0 && ee_cs) csd = n - 1;
      if (done) begin
        lat = n - 1;
        w = rd_word;
        if (busy) busy_err++;
        break;
      end
      if (!busy) busy_err++;
      if (n == 5 && div_new >= 0) div_half = 8'(div_new);
      if (n == 7 && ign_addr >= 0) begin req_valid = 1'b1; req_addr = 6'(ign_addr); end
      if (n == 8) req_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    if (lat < 0) begin
      w = '0;
      chk(1'b0, "R7 watchdog", n, 0);
    end
  endtask

  localparam logic [13:0] VEC [8] = '{
    {6'd0, 8'd0}, {6'd10, 8'd0}, {6'd11, 8'd1}, {6'd63, 8'd2},
    {6'd21, 8'd0}, {6'd42, 8'd3}, {6'd1, 8'd1}, {6'd32, 8'd0}
  };

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int lat, csd, be;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({busy, done, ee_cs, ee_sk, ee_di} == 5'b0, "R1 reset outputs",
        {busy, done, ee_cs, ee_sk, ee_di}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = VEC[i][13:8];
      d = VEC[i][7:0];
      do_read(a, d, -1, -1, w, lat, csd, be);
      chk(w == swp(rom_word(a)), "R6 word", w, swp(rom_word(a)));
      chk(lat == 68 * (d + 1), "R7 latency", lat, 68 * (d + 1));
      chk(csd == d + 1, "R4 cs low phase", csd, d + 1);
      chk(be == 0, "R8 busy span", be, 0);
      @(negedge clk);
      chk(!done, "R9 done one cycle", done, 0);
      chk(m_last_cmd == (11'h180 | 11'(a)), "R2 command", m_last_cmd, 11'h180 | 11'(a));
      chk(m_last_rises == 27, "R5 clock count", m_last_rises, 27);
    end

    for (int a = 0; a < 32; a++) begin
      do_read(6'(a), 8'd0, -1, -1, w, lat, csd, be);
      chk(w == swp(rom_word(6'(a))), "R11 sweep", w, swp(rom_word(6'(a))));
    end

    do_read(6'd5, 8'd1, 3, -1, w, lat, csd, be);
    chk(lat == 136, "R7 divider latched", lat, 136);
    chk(w == swp(rom_word(6'd5)), "R7 word after div change", w, swp(rom_word(6'd5)));

    do_read(6'd9, 8'd0, -1, 50, w, lat, csd, be);
    chk(w == swp(rom_word(6'd9)), "R8 ignored request word", w, swp(rom_word(6'd9)));
    chk(m_last_cmd == (11'h180 | 11'd9), "R8 ignored request cmd", m_last_cmd, 11'h180 | 11'd9);
    be = 0;
    repeat (10) begin
      @(negedge clk);
      if (busy || ee_cs) be++;
    end
    chk(be == 0, "R8 no second transfer", be, 0);

    chk(hold_err == 0, "R3 di hold", hold_err, 0);
    chk(rdlow_err == 0, "R10 di low in read", rdlow_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule